// File: doc/BRIEF.md
# Raster Timing Generator with Biased Geometry Registers

This block produces the horizontal and vertical timing of a raster display. Its geometry comes from a set of 8-bit CRT controller register values. Each value is stored with a fixed bias. The vertical fields are wider than 8 bits, and their upper bits are held in a separate overflow byte. The block removes the biases and rebuilds the full-width counts from those bytes. It then runs a pixel counter and a line counter, and drives horizontal sync, vertical sync, an active-video flag and the current pixel and line position.

Horizontal geometry is counted in character clocks of 8 pixels. A pixel clock enable advances the raster by one pixel per enabled clock. The register values are plain inputs that the surrounding logic holds steady. Sync polarity and register access belong to the surrounding logic.

A parameter selects where the two top bits of the vertical total come from. They come either from the overflow byte (the default) or from the copies kept in an extension byte. The vertical sync pulse is placed a parameterised number of lines after the active area and lasts a parameterised number of lines.

Top module: `crtc_timing_gen`

## Requirements
- R1: After reset, pixX and lineY are 0. activeVideo is 1, and hSync and vSync follow the register values for position (0,0).
- R2: A clock with pixEn low changes neither pixX nor lineY.
- R3: The horizontal total in characters is regHTotal+5. pixX steps by one per enabled clock. After the last pixel of character regHTotal+4, pixX returns to 0. It also returns to 0 at the end of any character whose index is at or above the total minus one.
- R4: The vertical total in lines is V+2. V is a 10-bit value whose bit 9 is regOverflow bit 5, whose bit 8 is regOverflow bit 0, and whose low byte is regVTotal. lineY steps at each line wrap, and after line total−1 the frame restarts with pixX and lineY both 0.
- R5: The active width is (regHDispEnd+1)*8 pixels. activeVideo is 0 when pixX is at or beyond it.
- R6: The active height is D+1 lines. D is a 10-bit value whose bit 9 is regOverflow bit 6, whose bit 8 is regOverflow bit 1, and whose low byte is regVDispEnd. activeVideo is 1 only when pixX is within the active width and lineY is within the active height.
- R7: The sync start and end bytes hold the character position plus one. hSync is 1 when (character index + 1) ≥ regHSyncStart and (character index + 1) < regHSyncEnd. The character index is pixX/8.
- R8: vSync is 1 for lines H+VSYNC_DELAY up to H+VSYNC_DELAY+VSYNC_LINES−1, where H is the active height. The defaults are a delay of 1 and a pulse of 2 lines.
- R9: With VT_HIGH_FROM_EXT=0 (the default), regExt has no effect on any output. With VT_HIGH_FROM_EXT=1, regExt bits 7 and 6 supply bits 9 and 8 of the vertical total in place of the overflow bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixEn | input | 1 | Advance the raster by one pixel |
| regHTotal | input | 8 | Horizontal total in characters minus 5 |
| regHDispEnd | input | 8 | Active width in characters minus 1 |
| regHSyncStart | input | 8 | Horizontal sync start character plus 1 |
| regHSyncEnd | input | 8 | Horizontal sync end character plus 1 |
| regVTotal | input | 8 | Low byte of vertical total minus 2 |
| regVDispEnd | input | 8 | Low byte of active height minus 1 |
| regOverflow | input | 8 | Upper bits of the vertical fields (bits 0, 1, 5, 6) |
| regExt | input | 8 | Extension byte; bits 7:6 are a copy of vertical total bits 9:8 |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| activeVideo | output | 1 | Current pixel is inside the display area |
| pixX | output | 12 | Pixel position in the line |
| lineY | output | 11 | Line position in the frame |

## Verification
Each output comes straight from the counter state, so a wrong counter value shows at pixX or lineY in the same cycle it arises. A line wrap at the wrong character shows up in pixX within one line. A lost or misplaced overflow bit leaves lineY counting past, or short of, the decoded total, and the error shows at the first frame boundary. For that reason the bench runs configurations whose totals need bits 8 and 9 for at least one full frame. A wrong bias shows as activeVideo or a sync output changing one character or one line away from its expected place.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int REG_W     = 8;
  localparam int CHAR_PIX  = 8;
  localparam int CHAR_BITS = $clog2(CHAR_PIX);
  localparam int HCH_W     = REG_W + 1;            // biased total reaches 260
  localparam int X_W       = HCH_W + CHAR_BITS;
  localparam int Y_W       = REG_W + 3;            // 10-bit field plus bias

  typedef struct packed {
    logic [HCH_W-1:0] hTotal;   // characters per line
    logic [HCH_W-1:0] hDisp;    // active characters
    logic [HCH_W-1:0] hSyncOn;  // position + 1
    logic [HCH_W-1:0] hSyncOff; // position + 1
    logic [Y_W-1:0]   vTotal;   // lines per frame
    logic [Y_W-1:0]   vDisp;    // active lines
  } crtcGeom_t;

  typedef struct packed {
    logic pixStep;
    logic charEnd;
    logic lineWrap;
    logic frameWrap;
  } crtcStrobe_t;
endpackage

// File: rtl/crtc_geom_decode.sv
module crtc_geom_decode
  import crtc_pkg::*;
#(
  parameter bit VT_HIGH_FROM_EXT = 1'b0
) (
  input  logic [REG_W-1:0] regHTotal,
  input  logic [REG_W-1:0] regHDispEnd,
  input  logic [REG_W-1:0] regHSyncStart,
  input  logic [REG_W-1:0] regHSyncEnd,
  input  logic [REG_W-1:0] regVTotal,
  input  logic [REG_W-1:0] regVDispEnd,
  input  logic [REG_W-1:0] regOverflow,
  input  logic [REG_W-1:0] regExt,
  output crtcGeom_t        geom
);
  logic [1:0] vtHigh;
  logic       unusedBits;

  generate
    if (VT_HIGH_FROM_EXT) begin : g_vtFromExt
      assign vtHigh     = regExt[7:6];
      assign unusedBits = ^{regExt[5:0], regOverflow[7], regOverflow[5],
                            regOverflow[4:2], regOverflow[0]};
    end else begin : g_vtFromOverflow
      assign vtHigh     = {regOverflow[5], regOverflow[0]};
      assign unusedBits = ^{regExt, regOverflow[7], regOverflow[4:2]};
    end
  endgenerate

  always_comb begin
    geom.hTotal   = {1'b0, regHTotal} + HCH_W'(5);
    geom.hDisp    = {1'b0, regHDispEnd} + HCH_W'(1);
    geom.hSyncOn  = {1'b0, regHSyncStart};
    geom.hSyncOff = {1'b0, regHSyncEnd};
    geom.vTotal   = {1'b0, vtHigh, regVTotal} + Y_W'(2);
    geom.vDisp    = {1'b0, regOverflow[6], regOverflow[1], regVDispEnd} + Y_W'(1);
  end
endmodule

// File: rtl/crtc_ctrl.sv
module crtc_ctrl
  import crtc_pkg::*;
(
  input  logic                 pixEn,
  input  logic [CHAR_BITS-1:0] subPix,
  input  logic [HCH_W-1:0]     charCnt,
  input  logic [Y_W-1:0]       lineCnt,
  input  crtcGeom_t            geom,
  output crtcStrobe_t          strobe
);
  logic lastChar;
  logic lastLine;

  always_comb begin
    lastChar         = charCnt >= (geom.hTotal - HCH_W'(1));
    lastLine         = lineCnt >= (geom.vTotal - Y_W'(1));
    strobe.pixStep   = pixEn;
    strobe.charEnd   = pixEn && (subPix == CHAR_BITS'(CHAR_PIX - 1));
    strobe.lineWrap  = strobe.charEnd && lastChar;
    strobe.frameWrap = strobe.lineWrap && lastLine;
  end
endmodule

// File: rtl/crtc_dp.sv
module crtc_dp
  import crtc_pkg::*;
#(
  parameter int VSYNC_DELAY = 1,
  parameter int VSYNC_LINES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  crtcStrobe_t          strobe,
  input  crtcGeom_t            geom,
  output logic [CHAR_BITS-1:0] subPix,
  output logic [HCH_W-1:0]     charCnt,
  output logic [Y_W-1:0]       lineCnt,
  output logic                 hSync,
  output logic                 vSync,
  output logic                 activeVideo,
  output logic [X_W-1:0]       pixX,
  output logic [Y_W-1:0]       lineY
);
  logic [HCH_W:0] charPlusOne;
  logic [Y_W:0]   vsOn;
  logic [Y_W:0]   vsOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subPix  <= '0;
      charCnt <= '0;
      lineCnt <= '0;
    end else if (strobe.pixStep) begin
      if (strobe.charEnd) begin
        subPix  <= '0;
        charCnt <= strobe.lineWrap ? '0 : charCnt + HCH_W'(1);
      end else begin
        subPix <= subPix + CHAR_BITS'(1);
      end
      if (strobe.frameWrap)     lineCnt <= '0;
      else if (strobe.lineWrap) lineCnt <= lineCnt + Y_W'(1);
    end
  end

  always_comb begin
    charPlusOne = {1'b0, charCnt} + (HCH_W+1)'(1);
    vsOn        = {1'b0, geom.vDisp} + (Y_W+1)'(VSYNC_DELAY);
    vsOff       = vsOn + (Y_W+1)'(VSYNC_LINES);
    pixX        = {charCnt, subPix};
    lineY       = lineCnt;
    activeVideo = (charCnt < geom.hDisp) && (lineCnt < geom.vDisp);
    hSync       = (charPlusOne >= {1'b0, geom.hSyncOn}) &&
                  (charPlusOne <  {1'b0, geom.hSyncOff});
    vSync       = ({1'b0, lineCnt} >= vsOn) && ({1'b0, lineCnt} < vsOff);
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pixStep |=> $stable(subPix) && $stable(charCnt) && $stable(lineCnt)); // R2
  AST_PIXEL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pixStep && !strobe.charEnd |=>
      (subPix == $past(subPix) + CHAR_BITS'(1)) && $stable(charCnt) && $stable(lineCnt)); // R3
  AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lineWrap && !strobe.frameWrap |=>
      (lineCnt == $past(lineCnt) + Y_W'(1)) && (charCnt == '0) && (subPix == '0)); // R4
  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameWrap |=> (charCnt == '0) && (subPix == '0) && (lineCnt == '0)); // R4
endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
  import crtc_pkg::*;
#(
  parameter int VSYNC_DELAY      = 1,
  parameter int VSYNC_LINES      = 2,
  parameter bit VT_HIGH_FROM_EXT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixEn,
  input  logic [REG_W-1:0] regHTotal,
  input  logic [REG_W-1:0] regHDispEnd,
  input  logic [REG_W-1:0] regHSyncStart,
  input  logic [REG_W-1:0] regHSyncEnd,
  input  logic [REG_W-1:0] regVTotal,
  input  logic [REG_W-1:0] regVDispEnd,
  input  logic [REG_W-1:0] regOverflow,
  input  logic [REG_W-1:0] regExt,
  output logic             hSync,
  output logic             vSync,
  output logic             activeVideo,
  output logic [X_W-1:0]   pixX,
  output logic [Y_W-1:0]   lineY
);
  crtcGeom_t            geom;
  crtcStrobe_t          strobe;
  logic [CHAR_BITS-1:0] subPix;
  logic [HCH_W-1:0]     charCnt;
  logic [Y_W-1:0]       lineCnt;

  crtc_geom_decode #(.VT_HIGH_FROM_EXT(VT_HIGH_FROM_EXT)) u_decode (
    .regHTotal(regHTotal), .regHDispEnd(regHDispEnd),
    .regHSyncStart(regHSyncStart), .regHSyncEnd(regHSyncEnd),
    .regVTotal(regVTotal), .regVDispEnd(regVDispEnd),
    .regOverflow(regOverflow), .regExt(regExt), .geom(geom)
  );

  crtc_ctrl u_ctrl (
    .pixEn(pixEn), .subPix(subPix), .charCnt(charCnt),
    .lineCnt(lineCnt), .geom(geom), .strobe(strobe)
  );

  crtc_dp #(.VSYNC_DELAY(VSYNC_DELAY), .VSYNC_LINES(VSYNC_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .geom(geom),
    .subPix(subPix), .charCnt(charCnt), .lineCnt(lineCnt),
    .hSync(hSync), .vSync(vSync), .activeVideo(activeVideo),
    .pixX(pixX), .lineY(lineY)
  );
endmodule

// File: tb/test_crtc_timing_gen.sv
module test_crtc_timing_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixEn = 1'b0;
  logic [7:0] regHTotal, regHDispEnd, regHSyncStart, regHSyncEnd;
  logic [7:0] regVTotal, regVDispEnd, regOverflow, regExt;
  logic hSync, vSync, activeVideo;
  logic [11:0] pixX;
  logic [10:0] lineY;

  int checks = 0;
  int errors = 0;
  int bx = 0;
  int by = 0;
  bit done = 1'b0;
  string tagX = "R3";

  always #5 clk = ~clk;

  crtc_timing_gen i_crtc_timing_gen (
    .clk(clk), .rstN(rstN), .pixEn(pixEn),
    .regHTotal(regHTotal), .regHDispEnd(regHDispEnd),
    .regHSyncStart(regHSyncStart), .regHSyncEnd(regHSyncEnd),
    .regVTotal(regVTotal), .regVDispEnd(regVDispEnd),
    .regOverflow(regOverflow), .regExt(regExt),
    .hSync(hSync), .vSync(vSync), .activeVideo(activeVideo),
    .pixX(pixX), .lineY(lineY)
  );

  function automatic int expHTot();  return int'(regHTotal) + 5; endfunction
  function automatic int expHDisp(); return int'(regHDispEnd) + 1; endfunction
  function automatic int expVTot();
    return (int'(regOverflow[5]) << 9) + (int'(regOverflow[0]) << 8) + int'(regVTotal) + 2;
  endfunction
  function automatic int expVDisp();
    return (int'(regOverflow[6]) << 9) + (int'(regOverflow[1]) << 8) + int'(regVDispEnd) + 1;
  endfunction

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (x=%0d y=%0d)", tag, act, exp, bx, by);
    end
  endtask

  task automatic checkAll(string extra);
    int ch = bx / 8;
    int vd = expVDisp();
    checkVal({tagX, extra, " pixX"}, int'(pixX), bx);
    checkVal({"R4", extra, " lineY"}, int'(lineY), by);
    checkVal({"R5 R6", extra, " activeVideo"}, int'(activeVideo),
             int'(ch < expHDisp() && by < vd));
    checkVal({"R7", extra, " hSync"}, int'(hSync),
             int'((ch + 1) >= int'(regHSyncStart) && (ch + 1) < int'(regHSyncEnd)));
    checkVal({"R8", extra, " vSync"}, int'(vSync),
             int'(by >= vd + 1 && by < vd + 3));
  endtask

  task automatic modelStep();
    if (bx % 8 == 7) begin
      if (bx / 8 >= expHTot() - 1) begin
        bx = 0;
        if (by >= expVTot() - 1) by = 0;
        else by = by + 1;
      end else bx = bx + 1;
    end else bx = bx + 1;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    bx = 0;
    by = 0;
    #1;
    checkAll(" R1 reset");
  endtask

  task automatic run(int cycles, int enPct, string extra);
    for (int i = 0; i < cycles; i++) begin
      bit en = ($urandom % 100) < enPct;
      pixEn = en;
      tagX = en ? "R3" : "R2";
      @(posedge clk);
      #2;
      if (en) modelStep();
      checkAll(extra);
      @(negedge clk);
    end
    pixEn = 1'b0;
  endtask

  task automatic setRegs(int ht, int hd, int hs, int he, int vt, int vd, int ov, int ex);
    regHTotal = 8'(ht); regHDispEnd = 8'(hd);
    regHSyncStart = 8'(hs); regHSyncEnd = 8'(he);
    regVTotal = 8'(vt); regVDispEnd = 8'(vd);
    regOverflow = 8'(ov); regExt = 8'(ex);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 R3 R5 R7: small directed geometry, enable always high
    setRegs(3, 5, 7, 8, 10, 8, 0, 0);
    @(negedge clk);
    doReset();
    run(2000, 100, "");
    // R2: sparse enable must freeze position
    doReset();
    run(3000, 50, "");
    // R4 R6: overflow bits 0 and 1 carry bit 8 (263 lines, 257 active)
    setRegs(0, 3, 1, 3, 5, 0, 8'h03 | 8'h9C, 0);
    doReset();
    run(11000, 100, " ovf-bit8");
    // R4 R6: overflow bits 5 and 6 carry bit 9 (514 lines, 514 active)
    setRegs(0, 4, 5, 6, 0, 1, 8'h60, 0);
    doReset();
    run(21000, 100, " ovf-bit9");
    // R9: extension byte has no effect in the default variant
    setRegs(3, 5, 7, 8, 10, 8, 0, 8'hFF);
    doReset();
    run(1000, 100, " R9 ext=FF");
    regExt = 8'hC0;
    run(1000, 80, " R9 ext=C0");
    // mixed random geometry
    for (int k = 0; k < 8; k++) begin
      int ht = $urandom % 7;
      int vt = $urandom % 21;
      setRegs(ht, $urandom % (ht + 5), $urandom % 13, $urandom % 13,
              vt, $urandom % (vt + 2), ($urandom % 256) & 8'h9C, $urandom % 256);
      doReset();
      run(3000, 75, " rand");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule